// File: doc/BRIEF.md
# Pipelined Loop Branch Controller

This block resolves the loop-closing branches of a core that runs software-pipelined loops on a rotating register file. The block holds two architectural counters. The iteration counter holds the trip count minus one. The drain counter holds the number of pipeline stages. Each time a loop branch executes, the block decides whether the branch is taken and updates the counters. It also decides whether the rotating register bases must step down. If they do, it gives the value to write into the highest rotating predicate just before the rotation. After the rotation that value is seen as the first stage predicate.

Three branch flavours are decoded. The first is a plain counted loop that does not rotate. The second is a pipelined counted loop. The third is a pipelined while loop, which is steered by a qualifying predicate in place of the iteration counter. In the two pipelined flavours, the loop keeps running after the main count is used up, for as many extra trips as the drain counter allows. During those trips the injected stage predicate is 0, so the pipeline empties without any epilogue code. Software can load either counter directly on a write port.

The branch request is a plain single-cycle strobe with no back-pressure: the block accepts one request in every cycle. The result is registered. The decision, the rotate strobe and the predicate value appear on the outputs in the cycle after the request, together with the updated counter values. Computing the branch target and redirecting fetch are handled elsewhere.

Top module: `loop_branch_ctl`

## Requirements
- R1: After reset, both counters read 0 and `res_valid` is 0.
- R2: Branch kind 2'b01 (counted, no rotation): if the iteration counter is nonzero, the counter decrements and the branch is taken. If the counter is 0, the branch falls through and the counter stays 0. In both cases `res_rotate` is 0.
- R3: Branch kind 2'b10 (pipelined counted) with a nonzero iteration counter: the iteration counter decrements, the drain counter is unchanged, `res_stage_pred` is 1, `res_rotate` is 1, and the branch is taken.
- R4: Branch kind 2'b10 with the iteration counter at 0 and the drain counter above 1: the drain counter decrements, `res_stage_pred` is 0, `res_rotate` is 1, and the branch is taken.
- R5: Branch kind 2'b10 with the iteration counter at 0 and the drain counter at 1 or 0: the drain counter decrements and holds at 0 instead of wrapping, `res_stage_pred` is 0, `res_rotate` is 1, and the branch falls through.
- R6: Branch kind 2'b11 (pipelined while): when `br_qp` is 1, the branch is taken with `res_stage_pred` 1 and `res_rotate` 1, and both counters are unchanged. When `br_qp` is 0, the drain rules of R4 and R5 apply, and the iteration counter is unchanged.
- R7: A counter write in the same cycle as a branch wins. The counter takes the written value, and the branch result is still computed from the counter values held before that edge.
- R8: A cycle with `br_valid` low, or with branch kind 2'b00, produces no result (`res_valid` 0) and leaves both counters unchanged.
- R9: The result of a request appears, with `res_valid` high, exactly one cycle after the request. `res_valid` lasts for one cycle per request.
- R10: Starting from an iteration count of 3 and a drain count of 4, seven pipelined counted branches give six taken and then one fall-through. There are seven rotations, and both counters end at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A loop branch executes this cycle |
| br_kind | input | 2 | 01 counted, 10 pipelined counted, 11 pipelined while, 00 reserved |
| br_qp | input | 1 | Qualifying predicate for the while flavour |
| lc_wr_en | input | 1 | Load the iteration counter |
| lc_wr_data | input | LC_W | Value loaded into the iteration counter |
| ec_wr_en | input | 1 | Load the drain counter |
| ec_wr_data | input | EC_W | Value loaded into the drain counter |
| res_valid | output | 1 | A branch result is presented |
| res_taken | output | 1 | 1 taken, 0 fall-through |
| res_rotate | output | 1 | Strobe to step the rotating bases down |
| res_stage_pred | output | 1 | Value written to the top rotating predicate before rotation |
| lc_value | output | LC_W | Current iteration counter |
| ec_value | output | EC_W | Current drain counter |

## Verification
The hardest case to reach is the boundary between the kernel phase and the drain phase in the same loop, especially with a counter write landing in the same cycle as that branch. Random stimulus reaches it only by chance, because the counters need small values to run out within a few branches. The random loop therefore loads the counters only with values below six, fires branches in three cycles out of four, and often lets writes coincide with branches. A directed run of the full kernel-then-drain sequence and directed writes at the zero floor cover the remaining corners.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  typedef enum logic [1:0] {
    BK_NONE  = 2'b00,
    BK_CLOOP = 2'b01,
    BK_CTOP  = 2'b10,
    BK_WTOP  = 2'b11
  } br_kind_e;

  typedef struct packed {
    logic act;
    logic taken;
    logic rotate;
    logic stage_pred;
  } lbc_verdict_t;

endpackage

// File: rtl/lbc_counter.sv
module lbc_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         dec_en,
  output logic [W-1:0] q
);
  logic at_floor;
  assign at_floor = (q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                  q <= '0;
    else if (wr_en)              q <= wr_data;
    else if (dec_en && !at_floor) q <= q - 1'b1;
  end

  AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    at_floor && !wr_en |=> q == '0);  // R5
endmodule

// File: rtl/lbc_decide.sv
module lbc_decide
  import lbc_pkg::*;
#(
  parameter int LC_W = 16,
  parameter int EC_W = 6
) (
  input  br_kind_e         kind,
  input  logic             qp,
  input  logic [LC_W-1:0]  lc,
  input  logic [EC_W-1:0]  ec,
  output lbc_verdict_t     verdict,
  output logic             lc_dec,
  output logic             ec_dec
);
  localparam logic [EC_W-1:0] EC_ONE = EC_W'(1);

  logic lc_nz, ec_more;
  assign lc_nz   = (lc != '0);
  assign ec_more = (ec > EC_ONE);

  always_comb begin
    verdict = '0;
    lc_dec  = 1'b0;
    ec_dec  = 1'b0;
    unique case (kind)
      BK_CLOOP: begin
        verdict.act   = 1'b1;
        verdict.taken = lc_nz;
        lc_dec        = lc_nz;
      end
      BK_CTOP, BK_WTOP: begin
        verdict.act    = 1'b1;
        verdict.rotate = 1'b1;
        if ((kind == BK_CTOP) ? lc_nz : qp) begin
          verdict.taken      = 1'b1;
          verdict.stage_pred = 1'b1;
          lc_dec             = (kind == BK_CTOP);
        end else begin
          verdict.taken = ec_more;
          ec_dec        = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/loop_branch_ctl.sv
module loop_branch_ctl
  import lbc_pkg::*;
#(
  parameter int LC_W = 16,
  parameter int EC_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_valid,
  input  logic [1:0]      br_kind,
  input  logic            br_qp,
  input  logic            lc_wr_en,
  input  logic [LC_W-1:0] lc_wr_data,
  input  logic            ec_wr_en,
  input  logic [EC_W-1:0] ec_wr_data,
  output logic            res_valid,
  output logic            res_taken,
  output logic            res_rotate,
  output logic            res_stage_pred,
  output logic [LC_W-1:0] lc_value,
  output logic [EC_W-1:0] ec_value
);
  br_kind_e     kind_in;
  lbc_verdict_t verdict;
  logic         lc_dec, ec_dec;

  assign kind_in = br_valid ? br_kind_e'(br_kind) : BK_NONE;

  lbc_decide #(.LC_W(LC_W), .EC_W(EC_W)) u_decide (
    .kind(kind_in), .qp(br_qp), .lc(lc_value), .ec(ec_value),
    .verdict(verdict), .lc_dec(lc_dec), .ec_dec(ec_dec)
  );

  lbc_counter #(.W(LC_W)) u_lc (
    .clk(clk), .rst_n(rst_n), .wr_en(lc_wr_en), .wr_data(lc_wr_data),
    .dec_en(lc_dec), .q(lc_value)
  );

  lbc_counter #(.W(EC_W)) u_ec (
    .clk(clk), .rst_n(rst_n), .wr_en(ec_wr_en), .wr_data(ec_wr_data),
    .dec_en(ec_dec), .q(ec_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid      <= 1'b0;
      res_taken      <= 1'b0;
      res_rotate     <= 1'b0;
      res_stage_pred <= 1'b0;
    end else begin
      res_valid      <= verdict.act;
      res_taken      <= verdict.taken;
      res_rotate     <= verdict.rotate;
      res_stage_pred <= verdict.stage_pred;
    end
  end

  AST_CLOOP_NO_ROT: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && br_kind == 2'b01 |=> res_valid && !res_rotate);  // R2
  AST_KERNEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && br_kind == 2'b10 && lc_value != '0 && !lc_wr_en
    |=> lc_value == LC_W'($past(lc_value) - 1'b1) && res_taken && res_stage_pred);  // R3
  AST_DRAIN_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && br_kind == 2'b10 && lc_value == '0 |=> res_rotate && !res_stage_pred);  // R4
  AST_WTOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && br_kind == 2'b11 && br_qp && !ec_wr_en |=> $stable(ec_value));  // R6
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ec_wr_en |=> ec_value == $past(ec_wr_data));  // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> !res_valid);  // R8
endmodule

// File: tb/loop_branch_ctl_test.sv
module loop_branch_ctl_test;
  localparam int  LC_W  = 16;
  localparam int  EC_W  = 6;
  localparam time T_CLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic br_valid = 1'b0, br_qp = 1'b0, lc_wr_en = 1'b0, ec_wr_en = 1'b0;
  logic [1:0] br_kind = 2'b00;
  logic [LC_W-1:0] lc_wr_data = '0;
  logic [EC_W-1:0] ec_wr_data = '0;
  logic res_valid, res_taken, res_rotate, res_stage_pred;
  logic [LC_W-1:0] lc_value;
  logic [EC_W-1:0] ec_value;

  int checks = 0, fails = 0;
  logic [LC_W-1:0] m_lc;
  logic [EC_W-1:0] m_ec;

  always #(T_CLK/2) clk = ~clk;

  loop_branch_ctl #(.LC_W(LC_W), .EC_W(EC_W)) uut (.*);

  typedef struct packed {
    logic v, tk, rot, sp;
  } exp_t;

  function automatic exp_t predict(input logic vld, input logic [1:0] k, input logic qp,
                                   inout logic [LC_W-1:0] lc, inout logic [EC_W-1:0] ec);
    exp_t e = '0;
    if (!vld || k == 2'b00) return e;
    e.v = 1'b1;
    if (k == 2'b01) begin
      if (lc != 0) begin e.tk = 1'b1; lc = lc - 1; end
    end else begin
      e.rot = 1'b1;
      if ((k == 2'b10 && lc != 0) || (k == 2'b11 && qp)) begin
        e.tk = 1'b1; e.sp = 1'b1;
        if (k == 2'b10) lc = lc - 1;
      end else begin
        e.tk = (ec > 1);
        if (ec != 0) ec = ec - 1;
      end
    end
    return e;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic vld, input logic [1:0] k, input logic qp,
                      input logic lw, input logic [LC_W-1:0] ld,
                      input logic ew, input logic [EC_W-1:0] ed);
    exp_t e;
    br_valid = vld; br_kind = k; br_qp = qp;
    lc_wr_en = lw; lc_wr_data = ld; ec_wr_en = ew; ec_wr_data = ed;
    e = predict(vld, k, qp, m_lc, m_ec);
    if (lw) m_lc = ld;
    if (ew) m_ec = ed;
    @(negedge clk);
    br_valid = 1'b0; lc_wr_en = 1'b0; ec_wr_en = 1'b0;
    chk({req, " valid"}, 32'(res_valid), 32'(e.v));
    if (e.v) begin
      chk({req, " taken"}, 32'(res_taken), 32'(e.tk));
      chk({req, " rotate"}, 32'(res_rotate), 32'(e.rot));
      chk({req, " pred"}, 32'(res_stage_pred), 32'(e.sp));
    end
    chk({req, " lc"}, 32'(lc_value), 32'(m_lc));
    chk({req, " ec"}, 32'(ec_value), 32'(m_ec));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int taken_n, rot_n;
    void'($urandom(32'h5eed_1234));
    m_lc = '0; m_ec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 lc reset", 32'(lc_value), 0);
    chk("R1 ec reset", 32'(ec_value), 0);
    chk("R1 valid reset", 32'(res_valid), 0);

    // R10 worked sequence
    step("R7 load", 1'b0, 2'b00, 1'b0, 1'b1, 16'd3, 1'b1, 6'd4);
    taken_n = 0; rot_n = 0;
    for (int i = 0; i < 7; i++) begin
      step("R10 ctop", 1'b1, 2'b10, 1'b0, 1'b0, '0, 1'b0, '0);
      taken_n += res_taken; rot_n += res_rotate;
      if (i == 6) chk("R10 last falls", 32'(res_taken), 0);
    end
    chk("R10 taken count", 32'(taken_n), 6);
    chk("R10 rotations", 32'(rot_n), 7);
    // R5 floor: ec already 0
    step("R5 floor", 1'b1, 2'b10, 1'b0, 1'b0, '0, 1'b0, '0);
    // R2 counted at zero and nonzero
    step("R2 zero", 1'b1, 2'b01, 1'b0, 1'b0, '0, 1'b0, '0);
    step("R7 load", 1'b0, 2'b00, 1'b0, 1'b1, 16'd2, 1'b0, '0);
    step("R2 nonzero", 1'b1, 2'b01, 1'b0, 1'b0, '0, 1'b0, '0);
    // R7 write with branch same cycle
    step("R7 collide", 1'b1, 2'b10, 1'b0, 1'b1, 16'd9, 1'b1, 6'd3);
    // R6 while
    step("R6 qp1", 1'b1, 2'b11, 1'b1, 1'b0, '0, 1'b0, '0);
    step("R6 qp0", 1'b1, 2'b11, 1'b0, 1'b0, '0, 1'b0, '0);
    // R8 reserved kind and idle
    step("R8 reserved", 1'b1, 2'b00, 1'b1, 1'b0, '0, 1'b0, '0);
    step("R8 idle", 1'b0, 2'b10, 1'b0, 1'b0, '0, 1'b0, '0);
    // R9 one-cycle result
    step("R9 req", 1'b1, 2'b10, 1'b0, 1'b0, '0, 1'b0, '0);
    @(negedge clk);
    chk("R9 single pulse", 32'(res_valid), 0);

    for (int i = 0; i < 600; i++) begin
      logic v, lw, ew;
      v  = ($urandom % 4) != 0;
      lw = ($urandom % 8) == 0;
      ew = ($urandom % 8) == 0;
      step("R3 R4 R6 random", v, 2'($urandom % 4), 1'($urandom % 2),
           lw, LC_W'($urandom % 6), ew, EC_W'($urandom % 6));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule